// File: doc/BRIEF.md
# Configurable Multi-Source Parallel I/O Port

A bidirectional parallel port whose pins are set up one at a time by a processor over a small register bus. Each pad can carry one of four internal sources: a bit of a processor-written output register, a bit of an address word captured by a transparent latch, an output of an adjacent programmable logic array, or an external chip-select line. Whether a pad drives at all is set per pin by a direction bit. An external product-term enable can also turn the driver on. Because every pin has its own selection, one port can serve as general-purpose output, address bus and chip-select pins at the same moment.

The processor reads any port register back through one read multiplexer. It selects the output register, the direction register, the effective control word, the synchronized pad level or the logic-array outputs. The pad level passes through a two-flop synchronizer, which also feeds the logic array. A reduced variant (parameter `HAS_CTRL_REG = 0`, typically three pins wide) takes its per-pin selection from fixed configuration inputs instead of a writable control register.

Top module: `cfg_io_port`

## Requirements
- R1: While rst_ni is low and after its release, the output register, direction register and control register are zero, so pad_oe_o equals pt_oe_i and reads of offsets 0, 1 and 2 return 0.
- R2: With wr_en_i high at a rising clock edge, wr_data_i is written to the register at reg_addr_i: 0 output data, 1 direction (1 = output), 2 control. Reading the same offset (rd_data_o is combinational in reg_addr_i) then returns the written value.
- R3: Offset 3 and pin_sync_o return pad_i delayed by exactly two rising clock edges.
- R4: Offset 4 returns pla_out_i directly. Offsets 5 to 7 read as 0. Writes to offsets 3 to 7 change none of the registers at offsets 0 to 2.
- R5: A pin whose effective control bit is 0 drives pad_o with its output register bit.
- R6: A pin whose control bit is 1 and whose mode field is 2'b00 drives its bit of the address latch. The latch follows addr_i while ale_i is high and holds its value while ale_i is low. Pin i's mode field is mode_i[2i+1:2i].
- R7: A pin whose control bit is 1 drives its pla_out_i bit when its mode field is 2'b01. It drives its cs_i bit when the mode field is 2'b10 or 2'b11.
- R8: For every pin, pad_oe_o is high when its direction bit or its pt_oe_i bit is high, and low otherwise.
- R9: Pins are configured independently: source selection and output enable of one pin do not depend on any other pin's settings.
- R10: With HAS_CTRL_REG = 0, the effective control word is fixed_ctrl_i. Writes to offset 2 are ignored, and reads of offset 2 return fixed_ctrl_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register offset for write and read |
| wr_data_i | input | WIDTH | Write data |
| rd_data_o | output | WIDTH | Read multiplexer output |
| ale_i | input | 1 | Address latch enable, latch transparent when high |
| addr_i | input | WIDTH | Address bits to the latch |
| pla_out_i | input | WIDTH | Logic-array outputs |
| cs_i | input | WIDTH | External chip-select source per pin |
| mode_i | input | 2*WIDTH | Per-pin special-source select |
| fixed_ctrl_i | input | WIDTH | Fixed control word for the reduced variant |
| pt_oe_i | input | WIDTH | Product-term output enable per pin |
| pad_i | input | WIDTH | Pad input level |
| pad_o | output | WIDTH | Pad output value |
| pad_oe_o | output | WIDTH | Pad driver enable |
| pin_sync_o | output | WIDTH | Synchronized pad level to the logic array |

## Verification
The hardest situation to reach is a port whose pins use all four sources at once while the address latch is holding rather than following. That state needs the control word, the per-pin mode fields, a latch capture and a later change of addr_i with ale_i low, all in place together. The stimulus writes the registers first and opens the latch for one cycle to capture a value. It then closes the latch, moves addr_i, and compares every pad bit against a pin-by-pin model. The reduced variant is built as a second instance. An attempted control write there must leave both readback and pads unchanged.

// File: rtl/cfg_io_pkg.sv
package cfg_io_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_DATA = 3'd0,
    REG_DIR  = 3'd1,
    REG_CTRL = 3'd2,
    REG_PIN  = 3'd3,
    REG_PLA  = 3'd4
  } reg_sel_e;

  typedef enum logic [1:0] {
    SRC_ADDR = 2'b00,
    SRC_PLA  = 2'b01,
    SRC_CS   = 2'b10,
    SRC_CS2  = 2'b11
  } spec_src_e;
endpackage

// File: rtl/io_regfile.sv
module io_regfile
  import cfg_io_pkg::*;
#(
  parameter int unsigned WIDTH        = 8,
  parameter bit          HAS_CTRL_REG = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [WIDTH-1:0]  wr_data_i,
  input  logic [WIDTH-1:0]  fixed_ctrl_i,
  output logic [WIDTH-1:0]  data_o,
  output logic [WIDTH-1:0]  dir_o,
  output logic [WIDTH-1:0]  ctrl_raw_o,
  output logic [WIDTH-1:0]  ctrl_o
);
  logic wr_data, wr_dir, wr_ctrl;

  assign wr_data = wr_en_i && (reg_addr_i == REG_DATA);
  assign wr_dir  = wr_en_i && (reg_addr_i == REG_DIR);
  assign wr_ctrl = wr_en_i && (reg_addr_i == REG_CTRL) && HAS_CTRL_REG;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o     <= '0;
      dir_o      <= '0;
      ctrl_raw_o <= '0;
    end else begin
      if (wr_data) data_o     <= wr_data_i;
      if (wr_dir)  dir_o      <= wr_data_i;
      if (wr_ctrl) ctrl_raw_o <= wr_data_i;
    end
  end

  // reduced variant: selection fixed by configuration inputs
  assign ctrl_o = HAS_CTRL_REG ? ctrl_raw_o : fixed_ctrl_i;
endmodule

// File: rtl/io_addr_latch.sv
module io_addr_latch #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             rst_ni,
  input  logic             ale_i,
  input  logic [WIDTH-1:0] addr_i,
  output logic [WIDTH-1:0] lat_o
);
  always_latch begin
    if (!rst_ni)    lat_o = '0;
    else if (ale_i) lat_o = addr_i;
  end
endmodule

// File: rtl/io_sync.sv
module io_sync #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/io_pin_mux.sv
module io_pin_mux
  import cfg_io_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0]   data_i,
  input  logic [WIDTH-1:0]   dir_i,
  input  logic [WIDTH-1:0]   ctrl_i,
  input  logic [2*WIDTH-1:0] mode_i,
  input  logic [WIDTH-1:0]   lat_i,
  input  logic [WIDTH-1:0]   pla_i,
  input  logic [WIDTH-1:0]   cs_i,
  input  logic [WIDTH-1:0]   pt_oe_i,
  output logic [WIDTH-1:0]   pad_o,
  output logic [WIDTH-1:0]   pad_oe_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    spec_src_e sel;
    logic      spec;

    assign sel = spec_src_e'(mode_i[2*i +: 2]);

    always_comb begin
      unique case (sel)
        SRC_ADDR: spec = lat_i[i];
        SRC_PLA:  spec = pla_i[i];
        default:  spec = cs_i[i];
      endcase
    end

    assign pad_o[i]    = ctrl_i[i] ? spec : data_i[i];
    assign pad_oe_o[i] = dir_i[i] | pt_oe_i[i];
  end
endmodule

// File: rtl/io_readback.sv
module io_readback
  import cfg_io_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [WIDTH-1:0]  data_i,
  input  logic [WIDTH-1:0]  dir_i,
  input  logic [WIDTH-1:0]  ctrl_i,
  input  logic [WIDTH-1:0]  pin_i,
  input  logic [WIDTH-1:0]  pla_i,
  output logic [WIDTH-1:0]  rd_data_o
);
  always_comb begin
    unique case (reg_addr_i)
      REG_DATA: rd_data_o = data_i;
      REG_DIR:  rd_data_o = dir_i;
      REG_CTRL: rd_data_o = ctrl_i;
      REG_PIN:  rd_data_o = pin_i;
      REG_PLA:  rd_data_o = pla_i;
      default:  rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/cfg_io_port.sv
module cfg_io_port
  import cfg_io_pkg::*;
#(
  parameter int unsigned WIDTH        = 8,
  parameter bit          HAS_CTRL_REG = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [WIDTH-1:0]   wr_data_i,
  output logic [WIDTH-1:0]   rd_data_o,
  input  logic               ale_i,
  input  logic [WIDTH-1:0]   addr_i,
  input  logic [WIDTH-1:0]   pla_out_i,
  input  logic [WIDTH-1:0]   cs_i,
  input  logic [2*WIDTH-1:0] mode_i,
  input  logic [WIDTH-1:0]   fixed_ctrl_i,
  input  logic [WIDTH-1:0]   pt_oe_i,
  input  logic [WIDTH-1:0]   pad_i,
  output logic [WIDTH-1:0]   pad_o,
  output logic [WIDTH-1:0]   pad_oe_o,
  output logic [WIDTH-1:0]   pin_sync_o
);
  logic [WIDTH-1:0] data_q, dir_q, ctrl_q, ctrl_eff, lat_q;

  io_regfile #(.WIDTH(WIDTH), .HAS_CTRL_REG(HAS_CTRL_REG)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .reg_addr_i, .wr_data_i, .fixed_ctrl_i,
    .data_o(data_q), .dir_o(dir_q), .ctrl_raw_o(ctrl_q), .ctrl_o(ctrl_eff)
  );

  io_addr_latch #(.WIDTH(WIDTH)) u_lat (
    .rst_ni, .ale_i, .addr_i, .lat_o(lat_q)
  );

  io_sync #(.WIDTH(WIDTH)) u_sync (
    .clk_i, .rst_ni, .d_i(pad_i), .q_o(pin_sync_o)
  );

  io_pin_mux #(.WIDTH(WIDTH)) u_mux (
    .data_i(data_q), .dir_i(dir_q), .ctrl_i(ctrl_eff), .mode_i,
    .lat_i(lat_q), .pla_i(pla_out_i), .cs_i, .pt_oe_i,
    .pad_o, .pad_oe_o
  );

  io_readback #(.WIDTH(WIDTH)) u_rb (
    .reg_addr_i, .data_i(data_q), .dir_i(dir_q), .ctrl_i(ctrl_eff),
    .pin_i(pin_sync_o), .pla_i(pla_out_i), .rd_data_o
  );
endmodule

// File: rtl/io_port_chk.sv
module io_port_chk
  import cfg_io_pkg::*;
#(
  parameter int unsigned WIDTH        = 8,
  parameter bit          HAS_CTRL_REG = 1'b1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic [ADDR_W-1:0]  reg_addr_i,
  input logic [WIDTH-1:0]   wr_data_i,
  input logic               ale_i,
  input logic [WIDTH-1:0]   pt_oe_i,
  input logic [WIDTH-1:0]   pad_i,
  input logic [WIDTH-1:0]   pad_o,
  input logic [WIDTH-1:0]   pad_oe_o,
  input logic [WIDTH-1:0]   pin_sync_o,
  input logic [WIDTH-1:0]   data_q,
  input logic [WIDTH-1:0]   dir_q,
  input logic [WIDTH-1:0]   ctrl_q,
  input logic [WIDTH-1:0]   ctrl_eff,
  input logic [WIDTH-1:0]   lat_q
);
  logic [1:0] since_rst;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             since_rst <= '0;
    else if (since_rst != 3) since_rst <= since_rst + 2'd1;
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_reset_clear_r1: assert (data_q == '0 && dir_q == '0 && ctrl_q == '0)
        else $error("registers not cleared in reset");
    end
  end

  p_dir_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && reg_addr_i == REG_DIR |=> dir_q == $past(wr_data_i));

  p_sync_delay_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    since_rst >= 2 |-> pin_sync_o == $past(pad_i, 2));

  p_ro_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && reg_addr_i > REG_CTRL |=> $stable(data_q) && $stable(dir_q) && $stable(ctrl_q));

  p_data_src_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_o ^ data_q) & ~ctrl_eff) == '0);

  p_latch_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ale_i && $past(!ale_i) && since_rst >= 1 |-> $stable(lat_q));

  p_pt_oe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o & pt_oe_i) == pt_oe_i);

  p_ctrl_fixed_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !HAS_CTRL_REG |-> ctrl_q == '0);
endmodule

bind cfg_io_port io_port_chk #(.WIDTH(WIDTH), .HAS_CTRL_REG(HAS_CTRL_REG)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .reg_addr_i(reg_addr_i),
  .wr_data_i(wr_data_i), .ale_i(ale_i), .pt_oe_i(pt_oe_i), .pad_i(pad_i),
  .pad_o(pad_o), .pad_oe_o(pad_oe_o), .pin_sync_o(pin_sync_o),
  .data_q(data_q), .dir_q(dir_q), .ctrl_q(ctrl_q), .ctrl_eff(ctrl_eff), .lat_q(lat_q)
);

// File: tb/sim_cfg_io_port.sv
`timescale 1ns/1ps
module sim_cfg_io_port;
  localparam int W  = 8;
  localparam int WR = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // full instance
  logic          wr_en = 0;
  logic [2:0]    raddr = 0;
  logic [W-1:0]  wdata = 0, rdata, addr = 0, pla = 0, cs = 0, fixc = 0, pt_oe = 0, pad_in = 0;
  logic [2*W-1:0] mode = 0;
  logic          ale = 0;
  logic [W-1:0]  pad_out, pad_oe, pin_sync;

  cfg_io_port #(.WIDTH(W), .HAS_CTRL_REG(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .reg_addr_i(raddr), .wr_data_i(wdata),
    .rd_data_o(rdata), .ale_i(ale), .addr_i(addr), .pla_out_i(pla), .cs_i(cs),
    .mode_i(mode), .fixed_ctrl_i(fixc), .pt_oe_i(pt_oe), .pad_i(pad_in),
    .pad_o(pad_out), .pad_oe_o(pad_oe), .pin_sync_o(pin_sync)
  );

  // reduced instance
  logic           wr_en_r = 0;
  logic [2:0]     raddr_r = 0;
  logic [WR-1:0]  wdata_r = 0, rdata_r, pla_r = 0, fixc_r = 0, pad_out_r, pad_oe_r, sync_r;
  logic [2*WR-1:0] mode_r = 0;

  cfg_io_port #(.WIDTH(WR), .HAS_CTRL_REG(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en_r), .reg_addr_i(raddr_r), .wr_data_i(wdata_r),
    .rd_data_o(rdata_r), .ale_i(1'b0), .addr_i('0), .pla_out_i(pla_r), .cs_i('0),
    .mode_i(mode_r), .fixed_ctrl_i(fixc_r), .pt_oe_i('0), .pad_i('0),
    .pad_o(pad_out_r), .pad_oe_o(pad_oe_r), .pin_sync_o(sync_r)
  );

  task automatic chk(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [W-1:0] d);
    @(negedge clk); wr_en = 1; raddr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [W-1:0] d);
    raddr = a; #1; d = rdata;
  endtask

  // pin-by-pin model from R5..R7
  function automatic logic [W-1:0] model_pad(logic [W-1:0] d, logic [W-1:0] c,
      logic [2*W-1:0] m, logic [W-1:0] la, logic [W-1:0] pl, logic [W-1:0] cc);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) begin
      if (!c[i])                    r[i] = d[i];
      else if (m[2*i +: 2] == 2'b00) r[i] = la[i];
      else if (m[2*i +: 2] == 2'b01) r[i] = pl[i];
      else                          r[i] = cc[i];
    end
    return r;
  endfunction

  task automatic t_reset();
    logic [W-1:0] v;
    pt_oe = 8'h21; #1;
    chk("R1", "oe in reset", pad_oe, 8'h21);
    pt_oe = 0;
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    for (int a = 0; a < 3; a++) begin
      rd(3'(a), v); chk("R1", "reg after reset", v, 8'h00);
    end
    chk("R1", "oe after reset", pad_oe, 8'h00);
    chk("R1", "pad after reset", pad_out, 8'h00);
  endtask

  task automatic t_regs();
    logic [W-1:0] v;
    wr(3'd0, 8'hA5); rd(3'd0, v); chk("R2", "data readback", v, 8'hA5);
    wr(3'd1, 8'h3C); rd(3'd1, v); chk("R2", "dir readback", v, 8'h3C);
    wr(3'd2, 8'h81); rd(3'd2, v); chk("R2", "ctrl readback", v, 8'h81);
    wr(3'd2, 8'h00); wr(3'd1, 8'h00);
  endtask

  task automatic t_sync();
    logic [W-1:0] v;
    raddr = 3'd3;
    @(negedge clk); pad_in = 8'h5E;
    @(negedge clk); #1; chk("R3", "sync after one edge", rdata, 8'h00);
    @(negedge clk); #1; chk("R3", "sync after two edges", rdata, 8'h5E);
    chk("R3", "pin_sync_o", pin_sync, 8'h5E);
    rd(3'd3, v);
  endtask

  task automatic t_ro();
    logic [W-1:0] v;
    pla = 8'h96; rd(3'd4, v); chk("R4", "pla readback", v, 8'h96);
    wr(3'd0, 8'h11);
    wr(3'd3, 8'hFF); wr(3'd4, 8'hFF); wr(3'd5, 8'hFF); wr(3'd7, 8'hFF);
    rd(3'd0, v); chk("R4", "data after ro writes", v, 8'h11);
    rd(3'd1, v); chk("R4", "dir after ro writes", v, 8'h00);
    rd(3'd2, v); chk("R4", "ctrl after ro writes", v, 8'h00);
    rd(3'd6, v); chk("R4", "unmapped read", v, 8'h00);
    pla = 0;
  endtask

  task automatic t_data_src();
    wr(3'd0, 8'hC3); #1; chk("R5", "pad = data", pad_out, 8'hC3);
    wr(3'd0, 8'h3C); #1; chk("R5", "pad = data 2", pad_out, 8'h3C);
  endtask

  task automatic t_addr_src();
    mode = 0; wr(3'd2, 8'hFF);
    @(negedge clk); ale = 1; addr = 8'h5A; #1;
    chk("R6", "latch transparent", pad_out, 8'h5A);
    addr = 8'h77; #1; chk("R6", "latch follows", pad_out, 8'h77);
    @(negedge clk); ale = 0;
    @(negedge clk); addr = 8'h00;
    @(negedge clk); #1; chk("R6", "latch holds", pad_out, 8'h77);
  endtask

  task automatic t_pla_cs();
    pla = 8'hE1; cs = 8'h1E;
    mode = {8{2'b01}}; #1; chk("R7", "pla source", pad_out, 8'hE1);
    mode = {8{2'b10}}; #1; chk("R7", "cs source 10", pad_out, 8'h1E);
    mode = {8{2'b11}}; #1; chk("R7", "cs source 11", pad_out, 8'h1E);
    wr(3'd2, 8'h00); pla = 0; cs = 0; mode = 0;
  endtask

  task automatic t_oe();
    wr(3'd1, 8'h0F); pt_oe = 8'h00; #1; chk("R8", "oe from dir", pad_oe, 8'h0F);
    pt_oe = 8'h90; #1; chk("R8", "oe dir|pt", pad_oe, 8'h9F);
    wr(3'd1, 8'h00); #1; chk("R8", "oe pt only", pad_oe, 8'h90);
    pt_oe = 0;
  endtask

  task automatic t_mixed();
    @(negedge clk); ale = 1; addr = 8'h30;
    @(negedge clk); ale = 0;
    @(negedge clk); addr = 8'hCF;
    wr(3'd0, 8'h0A); wr(3'd2, 8'hF0); wr(3'd1, 8'h55);
    mode = 16'hE400; pla = 8'h00; cs = 8'hC0; #1;
    chk("R9", "mixed pads", pad_out, model_pad(8'h0A, 8'hF0, 16'hE400, 8'h30, 8'h00, 8'hC0));
    chk("R9", "mixed pads literal", pad_out, 8'hDA);
    chk("R9", "mixed oe", pad_oe, 8'h55);
    pla = 8'h20; #1; chk("R9", "only pin5 moves", pad_out, 8'hFA);
    wr(3'd2, 8'h00); wr(3'd1, 8'h00); mode = 0; pla = 0; cs = 0;
  endtask

  task automatic t_reduced();
    fixc_r = 3'b010; mode_r = 6'b000100; pla_r = 3'b010;
    @(negedge clk); wr_en_r = 1; raddr_r = 3'd0; wdata_r = 3'b101;
    @(negedge clk); wr_en_r = 0; #1;
    chk("R10", "reduced pads", {5'b0, pad_out_r}, 8'h07);
    @(negedge clk); wr_en_r = 1; raddr_r = 3'd2; wdata_r = 3'b000;
    @(negedge clk); wr_en_r = 0; #1;
    chk("R10", "ctrl readback fixed", {5'b0, rdata_r}, 8'h02);
    chk("R10", "pads after ctrl write", {5'b0, pad_out_r}, 8'h07);
    pla_r = 3'b000; #1;
    chk("R10", "pin1 follows pla", {5'b0, pad_out_r}, 8'h05);
  endtask

  initial begin
    t_reset();
    t_regs();
    t_sync();
    t_ro();
    t_data_src();
    t_addr_src();
    t_pla_cs();
    t_oe();
    t_mixed();
    t_reduced();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule